// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-facing side of a tile-based video processor. The CPU reaches it through eight register slots picked by a 3-bit select, with separate write and read strobes. The block holds the scroll and VRAM address state that the renderer needs. That state is a temporary (staged) VRAM address, the current VRAM address, a fine horizontal scroll, the background pattern base and the address step. It turns data-slot accesses into single reads or writes on a simple VRAM port.

Two double-write slots, scroll and address, share one first/second write toggle. Reading the status slot returns the vertical-blank flag, clears that flag and resets the toggle. Data reads go through a one-deep buffer, so a read returns the byte fetched by the previous read. Palette space is the exception: a read there returns the fresh byte at once. An interrupt request pulse goes to the CPU when vertical blank begins with interrupts enabled. It also fires when the enable bit is switched on while the flag is already set.

Slot map (CPU select value): 0 control, 1 mask, 2 status, 3 sprite address, 4 sprite data, 5 scroll, 6 address, 7 data. Control bits: [1:0] nametable select, [2] step (0 gives 1, 1 gives 32), [4] background base (0 gives 0x0000, 1 gives 0x1000), [7] interrupt enable.

Top module: `vp_regport`

## Requirements
- R1: After reset, the toggle, the temporary and current addresses, fine X, the read buffer, the control byte, reg_rdata and nmi_req are all zero.
- R2: A control write copies data bits 1:0 into temporary address bits 11:10 and leaves the other temporary bits unchanged.
- R3: Control bit 4 sets bg_base to 0x1000 (0x0000 when clear). Control bit 2 sets the step added to the current address after each data access to 32 (1 when clear).
- R4: nmi_req is a one-cycle pulse in the cycle after either of two events. One is a control write that takes bit 7 from 0 to 1 while the vblank flag is set. The other is a vblank_begin pulse that sets the flag while bit 7 is already 1. Neither event fires in any other case.
- R5: A first scroll write puts data bits 7:3 into temporary bits 4:0 and bits 2:0 into fine_x. A second scroll write puts bits 7:3 into temporary bits 9:5 and bits 2:0 into temporary bits 14:12.
- R6: A first address write puts data bits 5:0 into temporary bits 13:8 and clears bit 14. A second address write puts the data into temporary bits 7:0 and loads the whole resulting temporary address into the current address.
- R7: Scroll and address writes flip one shared toggle. A status read returns the toggle to the first-write state.
- R8: A status read returns the vblank flag in bit 7 with bits 6:0 zero, then clears the flag. A vblank_begin in the same cycle wins and leaves the flag set. vblank_end clears the flag.
- R9: A data read issues vram_rd at the current address. In the following cycle reg_rdata shows the old buffer contents, and the buffer takes vram_rdata.
- R10: When current address bits 13:8 are all ones (palette space), a data read shows the freshly fetched vram_rdata instead of the old buffer, and the buffer still takes that byte.
- R11: A data write drives vram_wr with the current address and reg_wdata in the same cycle. After each data access the current address becomes (address + step) modulo 0x4000.
- R12: A sprite-address write loads an 8-bit counter and each sprite-data write increments it modulo 256. Reads of slots 0, 1 and 3 return control, mask and that counter. Reads of slots 4, 5 and 6 return zero.
- R13: Each CPU access makes at most one VRAM access, and only on the data slot. When write and read strobes arrive together, the write is carried out and the read is ignored, leaving reg_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register slot select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid from the cycle after reg_rd |
| vblank_begin | input | 1 | Pulse from the renderer at start of vertical blank |
| vblank_end | input | 1 | Pulse from the renderer at end of vertical blank |
| nmi_req | output | 1 | One-cycle interrupt request to the CPU |
| vram_rd | output | 1 | VRAM read strobe |
| vram_wr | output | 1 | VRAM write strobe |
| vram_addr | output | 14 | VRAM address |
| vram_wdata | output | 8 | VRAM write data |
| vram_rdata | input | 8 | VRAM read data, valid in the cycle of vram_rd |
| cur_vaddr | output | 15 | Current VRAM address for the renderer |
| tmp_vaddr | output | 15 | Temporary VRAM address for the renderer |
| fine_x | output | 3 | Fine horizontal scroll |
| bg_base | output | 14 | Background pattern table base address |

## Verification
The VRAM strobes, address and write data follow the register strobes within the same cycle. The bench checks them just after it drives a falling-edge stimulus, before any clock edge. Address, scroll, fine X, background base and sprite-counter state change on the rising edge that samples the access. reg_rdata and nmi_req are registered and show their new values after that same edge. The bench holds every strobe from one falling edge to the next and checks the registered outputs at that second falling edge. A monitor process pops the expected read data from a queue once the read strobe has been taken at a rising edge, and compares it at the following falling edge.

// File: rtl/vp_regport_pkg.sv
package vp_regport_pkg;
  localparam int unsigned DW  = 8;   // CPU data width
  localparam int unsigned VW  = 15;  // scroll/address register width
  localparam int unsigned MW  = 14;  // VRAM address width
  localparam int unsigned FXW = 3;   // fine X width
  localparam int unsigned SW  = 3;   // slot select width

  localparam logic [VW-1:0] WRAP_MASK = VW'((1 << MW) - 1);
  localparam logic [VW-1:0] STEP_NEAR = VW'(1);
  localparam logic [VW-1:0] STEP_FAR  = VW'(32);
  localparam logic [MW-1:0] BG_HIGH   = MW'(14'h1000);

  // control byte bit positions
  localparam int unsigned C_NT   = 0;
  localparam int unsigned C_STEP = 2;
  localparam int unsigned C_BG   = 4;
  localparam int unsigned C_IRQ  = 7;

  typedef enum logic [SW-1:0] {
    SLOT_CTRL = 3'd0,
    SLOT_MASK = 3'd1,
    SLOT_STAT = 3'd2,
    SLOT_SPRA = 3'd3,
    SLOT_SPRD = 3'd4,
    SLOT_SCRL = 3'd5,
    SLOT_ADDR = 3'd6,
    SLOT_DATA = 3'd7
  } slot_e;
endpackage

// File: rtl/vp_scroll_addr.sv
module vp_scroll_addr
  import vp_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_scrl,
  input  logic          wr_addr,
  input  logic          rd_stat,
  input  logic          bump,
  input  logic          step_far,
  input  logic [DW-1:0] wdata,
  output logic [VW-1:0] tmp_q,
  output logic [VW-1:0] cur_q,
  output logic [FXW-1:0] fx_q,
  output logic          tog_q
);
  logic [VW-1:0]  tmp_d, cur_d, step;
  logic [FXW-1:0] fx_d;
  logic           tog_d, en;

  assign step = step_far ? STEP_FAR : STEP_NEAR;
  assign en   = wr_ctrl | wr_scrl | wr_addr | rd_stat | bump;

  always_comb begin
    tmp_d = tmp_q;
    cur_d = cur_q;
    fx_d  = fx_q;
    tog_d = tog_q;
    if (wr_ctrl) tmp_d[11:10] = wdata[1:0];
    if (wr_scrl) begin
      if (!tog_q) begin
        tmp_d[4:0] = wdata[7:3];
        fx_d       = wdata[2:0];
      end else begin
        tmp_d[9:5]   = wdata[7:3];
        tmp_d[14:12] = wdata[2:0];
      end
      tog_d = ~tog_q;
    end
    if (wr_addr) begin
      if (!tog_q) begin
        tmp_d[14]   = 1'b0;
        tmp_d[13:8] = wdata[5:0];
      end else begin
        tmp_d[7:0] = wdata;
        cur_d      = {tmp_q[14:8], wdata};
      end
      tog_d = ~tog_q;
    end
    if (rd_stat) tog_d = 1'b0;
    if (bump) cur_d = (cur_q + step) & WRAP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
      cur_q <= '0;
      fx_q  <= '0;
      tog_q <= 1'b0;
    end else if (en) begin
      tmp_q <= tmp_d;
      cur_q <= cur_d;
      fx_q  <= fx_d;
      tog_q <= tog_d;
    end
  end
endmodule

// File: rtl/vp_read_port.sv
module vp_read_port
  import vp_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [SW-1:0] sel,
  input  logic          palette,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] ctrl_v,
  input  logic [DW-1:0] mask_v,
  input  logic [DW-1:0] spra_v,
  input  logic          vbl,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] buf_q, buf_d, rdata_d;
  logic          buf_en;

  assign buf_en = rd_en && (sel == SLOT_DATA);
  assign buf_d  = mem_rdata;

  always_comb begin
    unique case (slot_e'(sel))
      SLOT_CTRL: rdata_d = ctrl_v;
      SLOT_MASK: rdata_d = mask_v;
      SLOT_STAT: rdata_d = {vbl, {(DW-1){1'b0}}};
      SLOT_SPRA: rdata_d = spra_v;
      SLOT_DATA: rdata_d = palette ? mem_rdata : buf_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end
endmodule

// File: rtl/vp_vblank_nmi.sv
module vp_vblank_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic vbl_begin,
  input  logic vbl_end,
  input  logic rd_stat,
  input  logic wr_ctrl,
  input  logic irq_en_old,
  input  logic irq_en_new,
  output logic vbl_q,
  output logic nmi_q
);
  logic vbl_d, nmi_d, vbl_en;

  assign vbl_en = vbl_begin | vbl_end | rd_stat;
  assign vbl_d  = vbl_begin;

  always_comb begin
    nmi_d = 1'b0;
    if (wr_ctrl && vbl_q && !irq_en_old && irq_en_new) nmi_d = 1'b1;
    if (vbl_begin && !vbl_q && irq_en_old)             nmi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vbl_q <= 1'b0;
    else if (vbl_en) vbl_q <= vbl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= nmi_d;
  end
endmodule

// File: rtl/vp_regport.sv
module vp_regport
  import vp_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          vblank_begin,
  input  logic          vblank_end,
  output logic          nmi_req,
  output logic          vram_rd,
  output logic          vram_wr,
  output logic [13:0]   vram_addr,
  output logic [7:0]    vram_wdata,
  input  logic [7:0]    vram_rdata,
  output logic [14:0]   cur_vaddr,
  output logic [14:0]   tmp_vaddr,
  output logic [2:0]    fine_x,
  output logic [13:0]   bg_base
);
  logic          wr_en, rd_en;
  logic          wr_ctrl, wr_mask, wr_scrl, wr_addr, wr_spra, wr_sprd, rd_stat;
  logic [DW-1:0] ctrl_q, ctrl_d, mask_q, spra_q, spra_d;
  logic          spra_en;
  logic          vbl_q, tog_q, palette;
  logic [VW-1:0] cur_q, tmp_q;

  // decode: a write takes the cycle, a coincident read is dropped
  assign wr_en   = reg_wr;
  assign rd_en   = reg_rd & ~reg_wr;
  assign wr_ctrl = wr_en && (reg_sel == SLOT_CTRL);
  assign wr_mask = wr_en && (reg_sel == SLOT_MASK);
  assign wr_spra = wr_en && (reg_sel == SLOT_SPRA);
  assign wr_sprd = wr_en && (reg_sel == SLOT_SPRD);
  assign wr_scrl = wr_en && (reg_sel == SLOT_SCRL);
  assign wr_addr = wr_en && (reg_sel == SLOT_ADDR);
  assign rd_stat = rd_en && (reg_sel == SLOT_STAT);

  assign vram_rd    = rd_en && (reg_sel == SLOT_DATA);
  assign vram_wr    = wr_en && (reg_sel == SLOT_DATA);
  assign vram_addr  = cur_q[MW-1:0];
  assign vram_wdata = reg_wdata;
  assign palette    = &cur_q[MW-1:8];

  assign ctrl_d  = reg_wdata;
  assign spra_en = wr_spra | wr_sprd;
  assign spra_d  = wr_spra ? reg_wdata : spra_q + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spra_q <= '0;
    else if (spra_en) spra_q <= spra_d;
  end

  vp_scroll_addr u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_scrl  (wr_scrl),
    .wr_addr  (wr_addr),
    .rd_stat  (rd_stat),
    .bump     (vram_rd | vram_wr),
    .step_far (ctrl_q[C_STEP]),
    .wdata    (reg_wdata),
    .tmp_q    (tmp_q),
    .cur_q    (cur_q),
    .fx_q     (fine_x),
    .tog_q    (tog_q)
  );

  vp_read_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .sel       (reg_sel),
    .palette   (palette),
    .mem_rdata (vram_rdata),
    .ctrl_v    (ctrl_q),
    .mask_v    (mask_q),
    .spra_v    (spra_q),
    .vbl       (vbl_q),
    .rdata_q   (reg_rdata)
  );

  vp_vblank_nmi u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .vbl_begin  (vblank_begin),
    .vbl_end    (vblank_end),
    .rd_stat    (rd_stat),
    .wr_ctrl    (wr_ctrl),
    .irq_en_old (ctrl_q[C_IRQ]),
    .irq_en_new (reg_wdata[C_IRQ]),
    .vbl_q      (vbl_q),
    .nmi_q      (nmi_req)
  );

  assign cur_vaddr = cur_q;
  assign tmp_vaddr = tmp_q;
  assign bg_base   = ctrl_q[C_BG] ? BG_HIGH : '0;
endmodule

// File: rtl/vp_regport_chk.sv
module vp_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_sel,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        vblank_begin,
  input logic        nmi_req,
  input logic        vram_rd,
  input logic        vram_wr,
  input logic [14:0] cur_vaddr,
  input logic [14:0] tmp_vaddr,
  input logic [7:0]  ctrl_q,
  input logic        vbl_q,
  input logic        tog_q
);
  // R4
  nmi_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R4
  nmi_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past((reg_wr && reg_sel == 3'd0) || vblank_begin));

  // R13
  one_vram_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_rd && vram_wr));

  // R11
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_rd || vram_wr) |=> !cur_vaddr[14]);

  // R11
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_rd || vram_wr) |=>
      cur_vaddr == (($past(cur_vaddr) + ($past(ctrl_q[2]) ? 15'd32 : 15'd1)) & 15'h3FFF));

  // R6
  addr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd6 && tog_q) |=> cur_vaddr == tmp_vaddr);

  // R7
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_sel == 3'd2) |=> !tog_q);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_sel == 3'd2 && !vblank_begin) |=> !vbl_q);
endmodule

bind vp_regport vp_regport_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_sel      (reg_sel),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .vblank_begin (vblank_begin),
  .nmi_req      (nmi_req),
  .vram_rd      (vram_rd),
  .vram_wr      (vram_wr),
  .cur_vaddr    (cur_vaddr),
  .tmp_vaddr    (tmp_vaddr),
  .ctrl_q       (ctrl_q),
  .vbl_q        (vbl_q),
  .tog_q        (tog_q)
);

// File: tb/tb_vp_regport.sv
module tb_vp_regport;
  logic        clk, rst_n;
  logic [2:0]  reg_sel;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        vblank_begin, vblank_end, nmi_req;
  logic        vram_rd, vram_wr;
  logic [13:0] vram_addr;
  logic [7:0]  vram_wdata, vram_rdata;
  logic [14:0] cur_vaddr, tmp_vaddr;
  logic [2:0]  fine_x;
  logic [13:0] bg_base;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  vp_regport dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] memf(logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction
  assign vram_rdata = memf(vram_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, logic [7:0] e, string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic vb(bit b, bit e);
    @(negedge clk);
    vblank_begin = b; vblank_end = e;
    @(negedge clk);
    vblank_begin = 1'b0; vblank_end = 1'b0;
  endtask

  // monitor: pop an expectation for every read the design accepts
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && reg_rd && !reg_wr) begin
        exp_t it;
        @(negedge clk);
        if (sb.size() == 0) chk("R9 unexpected read", 32'd1, 32'd0);
        else begin
          it = sb.pop_front();
          chk(it.tag, {24'd0, reg_rdata}, {24'd0, it.val});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_sel = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    vblank_begin = 0; vblank_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cur", cur_vaddr, 0);
    chk("R1 tmp", tmp_vaddr, 0);
    chk("R1 fine_x", fine_x, 0);
    chk("R1 nmi", nmi_req, 0);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 bg_base", bg_base, 0);

    // R2 nametable bits
    wr(3'd0, 8'h03);
    chk("R2 tmp", tmp_vaddr, 15'h0C00);
    // R3 base and step select
    wr(3'd0, 8'h14);
    chk("R2 tmp cleared", tmp_vaddr, 15'h0000);
    chk("R3 bg_base", bg_base, 14'h1000);
    rd(3'd0, 8'h14, "R12 ctrl read");

    // R5 scroll
    wr(3'd5, 8'hAD);
    chk("R5 fine_x", fine_x, 3'd5);
    chk("R5 coarse x", tmp_vaddr, 15'h0015);
    wr(3'd5, 8'h5E);
    chk("R5 y fields", tmp_vaddr, 15'h6175);

    // R7 shared toggle
    wr(3'd5, 8'h00);
    chk("R5 fine_x 0", fine_x, 3'd0);
    wr(3'd6, 8'h22);
    chk("R7 addr as second write", cur_vaddr, 15'h6122);
    wr(3'd6, 8'h3F);
    chk("R6 first write", tmp_vaddr, 15'h3F22);
    rd(3'd2, 8'h00, "R8 status no vblank");
    wr(3'd6, 8'h21);
    chk("R7 status reset toggle tmp", tmp_vaddr, 15'h2122);
    chk("R7 cur held", cur_vaddr, 15'h6122);
    wr(3'd6, 8'h05);
    chk("R6 copy", cur_vaddr, 15'h2105);

    // R11 data write, step 1
    wr(3'd0, 8'h00);
    @(negedge clk);
    reg_sel = 3'd7; reg_wdata = 8'h77; reg_wr = 1'b1;
    #1;
    chk("R11 vram_wr", vram_wr, 1);
    chk("R13 no read", vram_rd, 0);
    chk("R11 addr", vram_addr, 14'h2105);
    chk("R11 wdata", vram_wdata, 8'h77);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11 step 1", cur_vaddr, 15'h2106);

    // R9 buffered reads
    rd(3'd7, 8'h00, "R9 first read old buffer");
    chk("R11 after read", cur_vaddr, 15'h2107);
    rd(3'd7, memf(14'h2106), "R9 second read");
    wr(3'd0, 8'h04);
    rd(3'd7, memf(14'h2107), "R9 third read");
    chk("R3 step 32", cur_vaddr, 15'h2128);

    // R10 palette
    wr(3'd6, 8'h3F);
    wr(3'd6, 8'h10);
    rd(3'd7, memf(14'h3F10), "R10 palette immediate");
    chk("R3 step 32 palette", cur_vaddr, 15'h3F30);
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd6, 8'h10);
    rd(3'd7, memf(14'h3F10), "R10 buffer refilled");

    // R11 wrap
    wr(3'd6, 8'h3F);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'h11);
    chk("R11 wrap", cur_vaddr, 15'h0000);

    // R8 / R4 vblank and interrupt
    vb(1, 0);
    chk("R4 no nmi disabled", nmi_req, 0);
    rd(3'd2, 8'h80, "R8 status set");
    rd(3'd2, 8'h00, "R8 status cleared");
    vb(1, 0);
    wr(3'd0, 8'h80);
    chk("R4 nmi on enable", nmi_req, 1);
    @(negedge clk);
    chk("R4 nmi pulse ends", nmi_req, 0);
    wr(3'd0, 8'h80);
    chk("R4 no nmi already enabled", nmi_req, 0);
    vb(0, 1);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h80);
    chk("R4 no nmi without vblank", nmi_req, 0);
    vb(1, 0);
    chk("R4 nmi on vblank begin", nmi_req, 1);
    @(negedge clk);
    chk("R4 vblank pulse ends", nmi_req, 0);
    vb(0, 1);
    rd(3'd2, 8'h00, "R8 vblank_end clears");

    // R12 sprite address counter, other slots
    wr(3'd3, 8'hFE);
    @(negedge clk);
    reg_sel = 3'd4; reg_wdata = 8'h12; reg_wr = 1'b1;
    #1;
    chk("R13 sprite data no vram", vram_wr, 0);
    @(negedge clk);
    reg_wr = 1'b0;
    wr(3'd4, 8'h12);
    rd(3'd3, 8'h00, "R12 sprite addr wraps");
    wr(3'd1, 8'h1E);
    rd(3'd1, 8'h1E, "R12 mask read");
    rd(3'd5, 8'h00, "R12 scroll reads zero");

    // R13 simultaneous strobes
    @(negedge clk);
    reg_sel = 3'd7; reg_wdata = 8'h42; reg_wr = 1'b1; reg_rd = 1'b1;
    #1;
    chk("R13 write wins", vram_wr, 1);
    chk("R13 read dropped", vram_rd, 0);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R13 rdata held", reg_rdata, 8'h00);

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule